// File: doc/BRIEF.md
# Serial SAR Converter Readout Controller

This block is the host side of a three-wire link to a self-powering-down successive approximation converter. It drives an active-low select line and a serial clock, and it reads one input data line. It returns one 12-bit sample for each frame. A frame starts on a one-cycle request pulse, or on a free-running rate timer when automatic mode is on. Each frame runs for exactly sixteen serial clock periods. The converter shifts out four zero bits and then twelve data bits, most significant first. The controller samples each bit on a rising edge of the serial clock.

The serial clock is made from the system clock. Each phase lasts `HALF_DIV` system cycles, and the clock rests high while the select line is high. The controller holds off the first falling edge for a programmable setup time after the select line falls. After each frame it keeps the select line high for a programmable minimum idle time. This idle time covers the converter's power-down, power-up and acquisition needs. A request that arrives while a frame or the idle window is in progress is remembered and served once the window ends.

When a frame ends, the controller drops the four leading bits and presents the twelve data bits with a one-cycle valid strobe. If any of the leading bits read as 1, it also raises a framing error flag.

Top module: `adc_frame_ctrl`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), cs_n_o is 1, sclk_o is 1 and sample_valid_o is 0.
- R2: When cs_n_o falls, sclk_o stays high for exactly SETUP_CYC system cycles before its first falling edge.
- R3: While cs_n_o is low, sclk_o makes exactly 16 falling and 16 rising edges. While cs_n_o is high, sclk_o is 1.
- R4: Every serial clock phase inside a frame lasts HALF_DIV system cycles. After the 16th rising edge, sclk_o stays high for HALF_DIV cycles before cs_n_o rises.
- R5: sdata_i is sampled on each rising sclk_o edge. The first sampled bit is frame bit 15 and the last is bit 0. sample_o equals bits 11..0, with bit 11 taken from the 5th sampled bit.
- R6: frame_err_o is 1 when any of frame bits 15..12 (the first four sampled) is 1, and 0 otherwise. sample_o is delivered either way.
- R7: sample_valid_o pulses for exactly one cycle, in the cycle where cs_n_o returns high. sample_o and frame_err_o do not change between pulses.
- R8: Between frames, cs_n_o stays high for at least IDLE_CYC + 1 cycles. A request that is pending when the idle window ends lowers cs_n_o exactly IDLE_CYC + 1 cycles after it rose.
- R9: Any number of start_i pulses during one busy interval (frame or idle window) merge into a single following frame.
- R10: While auto_en_i is 1 and RATE_CYC is longer than a frame plus its idle window, successive cs_n_o falling edges are exactly RATE_CYC cycles apart. When auto_en_i is 0, no frames start without start_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request for a frame |
| auto_en_i | input | 1 | Enables the free-running rate timer |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low converter select |
| sclk_o | output | 1 | Serial clock, idle high |
| sample_o | output | 12 | Last received 12-bit sample, straight binary |
| sample_valid_o | output | 1 | One-cycle strobe when sample_o is updated |
| frame_err_o | output | 1 | A leading bit of the last frame was 1 |

## Verification
The hardest case to reach from the ports is a request that lands in the middle of a busy interval. Such a request has to wait out the rest of the frame and the whole idle window, and it must merge with any others, without being dropped or doubled. The bench sends several start pulses while the select line is low. It then checks that exactly two frames come out, and that the gap before the second frame is exactly the minimum idle length. Automatic mode reaches the same path through the rate timer, and the bench checks the spacing of select edges against the rate parameter.

// File: rtl/adc_frame_pkg.sv
// Shared constants and state encoding for the serial converter readout controller.
// Assumes a frame of LEAD_BITS zero bits followed by DATA_BITS data bits, MSB first.
package adc_frame_pkg;
    localparam int unsigned LEAD_BITS  = 4;
    localparam int unsigned DATA_BITS  = 12;
    localparam int unsigned FRAME_BITS = LEAD_BITS + DATA_BITS;

    typedef enum logic [2:0] {
        ST_READY,
        ST_SETUP,
        ST_SHIFT,
        ST_TAIL,
        ST_GAP
    } fsm_t;
endpackage

// File: rtl/adc_sclk_div.sv
// Half-period tick generator for the serial clock.
// Emits a one-cycle tick every HALF_DIV cycles while run is high; restarts when run is low.
// Assumes HALF_DIV >= 1.
module adc_sclk_div #(
    parameter int unsigned HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    // Count system cycles within one serial clock phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_rx_shift.sv
// Serial-in receive register for one frame.
// Shifts din in at each shift_en; splits the word into data bits and a leading-bit error flag.
// Assumes the caller clears it at frame launch and pulses shift_en once per rising serial edge.
module adc_rx_shift #(
    parameter int unsigned LEAD_BITS = 4,
    parameter int unsigned DATA_BITS = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 shift_en,
    input  logic                 din,
    output logic [DATA_BITS-1:0] data,
    output logic                 lead_err
);
    localparam int unsigned FW = LEAD_BITS + DATA_BITS;

    logic [FW-1:0] sh;

    // Collect frame bits, first received bit ends up in the top position.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sh <= '0;
        end else if (shift_en) begin
            sh <= {sh[FW-2:0], din};
        end
    end

    assign data     = sh[DATA_BITS-1:0];
    assign lead_err = |sh[FW-1:DATA_BITS];
endmodule

// File: rtl/adc_req_gate.sv
// Frame request holder with optional free-running rate timer.
// Merges any number of requests into one pending flag, cleared when a frame is launched.
// Assumes RATE_CYC >= 1; the timer restarts from zero whenever auto_en is low.
module adc_req_gate #(
    parameter int unsigned RATE_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic auto_en,
    input  logic take,
    output logic pend
);
    localparam int unsigned RW = (RATE_CYC > 1) ? $clog2(RATE_CYC) : 1;
    localparam logic [RW-1:0] RLAST = RW'(RATE_CYC - 1);

    logic [RW-1:0] rate_cnt;
    logic          rate_hit;

    assign rate_hit = auto_en && (rate_cnt == RLAST);

    // Free-running sample-rate timer.
    always_ff @(posedge clk) begin
        if (!rst_n || !auto_en || rate_hit) begin
            rate_cnt <= '0;
        end else begin
            rate_cnt <= rate_cnt + 1'b1;
        end
    end

    // Hold a request until the frame sequencer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else begin
            pend <= (pend | start | rate_hit) & ~take;
        end
    end
endmodule

// File: rtl/adc_frame_ctrl.sv
// Readout controller for a self-powering-down serial SAR converter.
// Runs setup, 16-period shift, tail and idle-gap phases; delivers a 12-bit sample with a strobe.
// Assumes SETUP_CYC >= 1, IDLE_CYC >= 1, HALF_DIV >= 1; all intervals are in system cycles.
module adc_frame_ctrl
    import adc_frame_pkg::*;
#(
    parameter int unsigned HALF_DIV  = 2,
    parameter int unsigned SETUP_CYC = 2,
    parameter int unsigned IDLE_CYC  = 10,
    parameter int unsigned RATE_CYC  = 100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 auto_en_i,
    input  logic                 sdata_i,
    output logic                 cs_n_o,
    output logic                 sclk_o,
    output logic [DATA_BITS-1:0] sample_o,
    output logic                 sample_valid_o,
    output logic                 frame_err_o
);
    localparam int unsigned MAXC  = (SETUP_CYC > IDLE_CYC) ? SETUP_CYC : IDLE_CYC;
    localparam int unsigned CNT_W = $clog2(MAXC + 1);
    localparam int unsigned BIT_W = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] IDLE_LAST  = CNT_W'(IDLE_CYC - 1);
    localparam logic [BIT_W-1:0] BIT_LAST   = BIT_W'(FRAME_BITS - 1);

    fsm_t                 state;
    logic [CNT_W-1:0]     cnt;
    logic [BIT_W-1:0]     bitc;
    logic                 cs_q, sclk_q, valid_q, err_q;
    logic [DATA_BITS-1:0] sample_q;
    logic                 pend, take, tick, div_run, shift_en;
    logic [DATA_BITS-1:0] rx_data;
    logic                 rx_err;

    assign take     = (state == ST_READY) && pend;
    assign div_run  = (state == ST_SHIFT) || (state == ST_TAIL);
    assign shift_en = (state == ST_SHIFT) && tick && !sclk_q;

    adc_req_gate #(.RATE_CYC(RATE_CYC)) u_req (
        .clk(clk), .rst_n(rst_n), .start(start_i), .auto_en(auto_en_i),
        .take(take), .pend(pend)
    );

    adc_sclk_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .run(div_run), .tick(tick)
    );

    adc_rx_shift #(.LEAD_BITS(LEAD_BITS), .DATA_BITS(DATA_BITS)) u_rx (
        .clk(clk), .rst_n(rst_n), .clear(take), .shift_en(shift_en),
        .din(sdata_i), .data(rx_data), .lead_err(rx_err)
    );

    // Frame sequencer: select, serial clock edges, sample hand-off and idle gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_READY;
            cnt      <= '0;
            bitc     <= '0;
            cs_q     <= 1'b1;
            sclk_q   <= 1'b1;
            valid_q  <= 1'b0;
            err_q    <= 1'b0;
            sample_q <= '0;
        end else begin
            valid_q <= 1'b0;
            unique case (state)
                ST_READY: begin
                    if (pend) begin
                        cs_q  <= 1'b0;
                        cnt   <= '0;
                        state <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (cnt == SETUP_LAST) begin
                        sclk_q <= 1'b0;
                        bitc   <= '0;
                        state  <= ST_SHIFT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!sclk_q) begin
                            sclk_q <= 1'b1;
                            if (bitc == BIT_LAST) begin
                                state <= ST_TAIL;
                            end else begin
                                bitc <= bitc + 1'b1;
                            end
                        end else begin
                            sclk_q <= 1'b0;
                        end
                    end
                end
                ST_TAIL: begin
                    if (tick) begin
                        cs_q     <= 1'b1;
                        valid_q  <= 1'b1;
                        sample_q <= rx_data;
                        err_q    <= rx_err;
                        cnt      <= '0;
                        state    <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (cnt == IDLE_LAST) begin
                        state <= ST_READY;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_READY;
            endcase
        end
    end

    assign cs_n_o         = cs_q;
    assign sclk_o         = sclk_q;
    assign sample_o       = sample_q;
    assign sample_valid_o = valid_q;
    assign frame_err_o    = err_q;
endmodule

// File: rtl/adc_frame_ctrl_chk.sv
// Property checker for the readout controller, attached by bind below.
// Watches only the top-level ports and keeps its own edge and gap counters.
module adc_frame_ctrl_chk #(
    parameter int unsigned IDLE_CYC   = 10,
    parameter int unsigned FRAME_BITS = 16,
    parameter int unsigned DATA_BITS  = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cs_n_o,
    input logic                 sclk_o,
    input logic [DATA_BITS-1:0] sample_o,
    input logic                 sample_valid_o,
    input logic                 frame_err_o
);
    logic [31:0] fall_cnt;
    logic [31:0] gap_cnt;
    logic        sclk_d;

    // Count serial clock falling edges inside the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d   <= 1'b1;
            fall_cnt <= '0;
        end else begin
            sclk_d <= sclk_o;
            if (cs_n_o) fall_cnt <= '0;
            else if (sclk_d && !sclk_o) fall_cnt <= fall_cnt + 1;
        end
    end

    // Count cycles with select high, saturating at the idle minimum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= IDLE_CYC;
        end else if (!cs_n_o) begin
            gap_cnt <= '0;
        end else if (gap_cnt < IDLE_CYC) begin
            gap_cnt <= gap_cnt + 1;
        end
    end

    a_r3_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> sclk_o);
    a_r2_setup_before_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> sclk_o);
    a_r3_sixteen_falls: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> fall_cnt == FRAME_BITS);
    a_r7_valid_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid_o |-> $rose(cs_n_o));
    a_r7_end_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> sample_valid_o);
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid_o |=> !sample_valid_o);
    a_r7_sample_held: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid_o |-> ($stable(sample_o) && $stable(frame_err_o)));
    a_r8_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> gap_cnt >= IDLE_CYC);
endmodule

bind adc_frame_ctrl adc_frame_ctrl_chk #(
    .IDLE_CYC(IDLE_CYC), .FRAME_BITS(adc_frame_pkg::FRAME_BITS),
    .DATA_BITS(adc_frame_pkg::DATA_BITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
    .sample_o(sample_o), .sample_valid_o(sample_valid_o), .frame_err_o(frame_err_o)
);

// File: tb/test_adc_frame_ctrl.sv
module test_adc_frame_ctrl;
    localparam int HALF = 2;
    localparam int SETUP = 2;
    localparam int IDLE = 6;
    localparam int RATE = 90;

    logic clk = 0, rst_n = 0, start_i = 0, auto_en_i = 0, sdata_i = 0;
    logic cs_n_o, sclk_o, sample_valid_o, frame_err_o;
    logic [11:0] sample_o;

    adc_frame_ctrl #(.HALF_DIV(HALF), .SETUP_CYC(SETUP), .IDLE_CYC(IDLE), .RATE_CYC(RATE))
    i_adc_frame_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .auto_en_i(auto_en_i),
        .sdata_i(sdata_i), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .sample_o(sample_o),
        .sample_valid_o(sample_valid_o), .frame_err_o(frame_err_o)
    );

    always #2 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0, frames = 0;
    logic [15:0] word = 16'h0;
    int idx = 0;

    // Converter model: next bit after each falling serial edge, MSB first.
    always @(negedge sclk_o or negedge cs_n_o) begin
        if (sclk_o) idx = 0;
        else begin
            sdata_i = (idx < 16) ? word[15 - idx] : 1'b0;
            idx = idx + 1;
        end
    end

    // Port monitor.
    logic prev_cs = 1, prev_sclk = 1;
    int run_len = 0, falls = 0, rises = 0, bad_phase = 0, setup_len = 0, tail_len = 0;
    int gap = 0, last_gap = 0, last_fall = 0, spacing = 0;
    always @(negedge clk) begin
        cyc++;
        if (sample_valid_o) frames++;
        if (rst_n) begin
            if (!cs_n_o && prev_cs) begin
                falls = 0; rises = 0; bad_phase = 0; run_len = 1; last_gap = gap;
                spacing = cyc - last_fall; last_fall = cyc;
            end else if (!cs_n_o) begin
                if (sclk_o != prev_sclk) begin
                    if (prev_sclk && falls == 0) setup_len = run_len;
                    else if (run_len != HALF) bad_phase++;
                    if (!sclk_o) falls++; else rises++;
                    run_len = 1;
                end else run_len++;
            end
            if (cs_n_o && !prev_cs) begin tail_len = run_len; gap = 1; end
            else if (cs_n_o) gap++;
        end
        prev_cs = cs_n_o; prev_sclk = sclk_o;
        if (cyc > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_valid(output bit got);
        int t = 0;
        got = 0;
        while (!sample_valid_o && t < 2000) begin @(negedge clk); t++; end
        got = sample_valid_o;
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1;
        @(negedge clk) start_i = 0;
    endtask

    task automatic do_frame(input logic [15:0] w);
        bit got;
        word = w;
        pulse_start();
        wait_valid(got);
        chk(got, "R7 valid seen", int'(got), 1);
        chk(cs_n_o == 1, "R7 valid with cs high", int'(cs_n_o), 1);
        @(negedge clk);
        chk(!sample_valid_o, "R7 single pulse", int'(sample_valid_o), 0);
        chk(sample_o == w[11:0], "R5 sample", int'(sample_o), int'(w[11:0]));
        chk(frame_err_o == (|w[15:12]), "R6 lead error", int'(frame_err_o), int'(|w[15:12]));
        chk(falls == 16, "R3 falling edges", falls, 16);
        chk(rises == 16, "R3 rising edges", rises, 16);
        chk(setup_len == SETUP, "R2 setup", setup_len, SETUP);
        chk(bad_phase == 0, "R4 phase length", bad_phase, 0);
        chk(tail_len == HALF, "R4 tail", tail_len, HALF);
    endtask

    initial begin
        bit got;
        int f0;
        logic [11:0] held;
        repeat (3) @(negedge clk);
        chk(cs_n_o == 1, "R1 cs_n reset", int'(cs_n_o), 1);
        chk(sclk_o == 1, "R1 sclk reset", int'(sclk_o), 1);
        chk(sample_valid_o == 0, "R1 valid reset", int'(sample_valid_o), 0);
        rst_n = 1;
        repeat (5) @(negedge clk);
        chk(cs_n_o == 1, "R1 idle without request", int'(cs_n_o), 1);

        do_frame(16'h0000);
        do_frame(16'h0FFF);
        for (int b = 0; b < 12; b++) do_frame(16'(1 << b));
        for (int k = 0; k < 64; k++) do_frame({4'h0, 12'((k * 331 + 17) % 4096)});
        for (int l = 0; l < 16; l++) do_frame({4'(l), 12'hA5C});

        // R7 hold: no change without a strobe.
        held = sample_o;
        repeat (40) @(negedge clk);
        chk(sample_o == held, "R7 sample held", int'(sample_o), int'(held));

        // R8 and R9: several requests while busy give one extra frame after the minimum gap.
        word = 16'h0123;
        f0 = frames;
        pulse_start();
        while (cs_n_o) @(negedge clk);
        repeat (3) begin pulse_start(); @(negedge clk); end
        wait_valid(got);
        @(negedge clk);
        wait_valid(got);
        @(negedge clk);
        chk(last_gap == IDLE + 1, "R8 gap before pending frame", last_gap, IDLE + 1);
        repeat (200) @(negedge clk);
        chk(frames - f0 == 2, "R9 merged requests", frames - f0, 2);
        chk(sample_o == 12'h123, "R5 sample after merge", int'(sample_o), 'h123);

        // R10: automatic mode spacing, then stop.
        word = 16'h0456;
        auto_en_i = 1;
        repeat (3) begin wait_valid(got); @(negedge clk); end
        chk(spacing == RATE, "R10 auto spacing", spacing, RATE);
        wait_valid(got);
        auto_en_i = 0;
        @(negedge clk);
        f0 = frames;
        repeat (300) @(negedge clk);
        chk(frames == f0, "R10 no frames when off", frames - f0, 0);
        chk(sample_o == 12'h456, "R5 auto sample", int'(sample_o), 'h456);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule